// File: doc/BRIEF.md
# Manchester Serial Word Encoder

This block turns a parallel word into a Manchester-coded serial frame at a quarter of the clock rate. A load strobe captures a 32-bit data word, a sync bit, a word-identifier bit and a separate 4-bit short word. A later enable edge starts a frame built from those captured values. Three select inputs choose the frame format, with a fixed priority between them. The formats are a 4-bit short word, a 34-bit word (sync, identifier, data) and a 35-bit word, which adds a parity bit after the data.

A path select sends the coded stream, with its complement, to one of two output pairs. One pair drives the line and the other feeds a self-test loop. The pair not in use rests at its own idle level: the line pair rests high and the self-test pair rests low. An asynchronous inhibit input forces both pairs to those rest levels at once. An active-high status output shows that no frame is being sent.

Top module: `manch_word_tx`

## Requirements
- R1: Each bit takes 2×HALF_CLKS clocks (4 by default). A 1 is sent high in the first half and low in the second, and a 0 the other way round. A 34-bit frame sends the sync bit first, then the identifier bit, then data bits 31 down to 0.
- R2: A 35-bit frame is the 34-bit frame followed by a parity bit. With `odd_par` low, the 35 sent bits hold an even number of ones. With `odd_par` high, they hold an odd number.
- R3: The frame format is read when a frame starts. `sel_short` has top priority, then `sel_34`, then `sel_35`.
- R4: With all three selects low, an enable edge is ignored: `tx_idle` stays high and the outputs stay at rest.
- R5: The short frame sends `short_in` bits 3 down to 0. It has no parity bit.
- R6: On the cycle where `load_n` goes from low to high, the inputs are captured. Changes to the inputs after that do not alter the frame. While `load_n` is low, any frame stops, and `tx_idle` is high on the next cycle.
- R7: `start` passes through a two-stage synchronizer, and only its rising edge starts a frame. If `start` rises at a cycle boundary, `tx_idle` is low three cycles later. An edge that comes during a frame is ignored.
- R8: `tx_idle` is low for exactly N×2×HALF_CLKS cycles, where N is the frame length. It is high again right after that.
- R9: With `tx_path` high, the frame drives `line_p`, with `line_n` as its complement, and `test_p`/`test_n` are low. With `tx_path` low, the frame drives `test_p`/`test_n` in the same way, and `line_p`/`line_n` are high.
- R10: While `inhibit_n` is low, `line_p`/`line_n` are high and `test_p`/`test_n` are low. This does not wait for a clock edge.
- R11: When no frame is being sent, `line_p`/`line_n` are high and `test_p`/`test_n` are low, whatever the value of `tx_path`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (four clocks per bit by default) |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Low: clear and idle; rising edge: capture inputs |
| word_in | input | 32 | Data word |
| sync_in | input | 1 | Sync bit |
| ident_in | input | 1 | Word-identifier bit |
| short_in | input | 4 | Short word |
| sel_short | input | 1 | Select 4-bit frame (top priority) |
| sel_34 | input | 1 | Select 34-bit frame |
| sel_35 | input | 1 | Select 35-bit frame with parity |
| odd_par | input | 1 | 0: even parity, 1: odd parity |
| start | input | 1 | Asynchronous enable; rising edge starts a frame |
| tx_path | input | 1 | 1: line pair, 0: self-test pair |
| inhibit_n | input | 1 | Asynchronous active-low output override |
| line_p | output | 1 | Line output, true |
| line_n | output | 1 | Line output, complement |
| test_p | output | 1 | Self-test output, true |
| test_n | output | 1 | Self-test output, complement |
| tx_idle | output | 1 | High while no frame is being sent |

## Verification
The bench builds the block with its defaults: a 32-bit word, a 4-bit short word, two clocks per half-bit and two synchronizer stages. With these values the parity bit falls in slot 34, near the top of the bit counter. The half-bit counter also has to wrap inside every bit. The bench checks every cycle of each frame against a model of the expected waveform, on whichever pair is active and on the pair at rest. The frames cover each priority combination, both parity senses, a mid-frame enable edge, a load-clear abort and the asynchronous inhibit.

// File: rtl/mwt_pkg.sv
// Shared types for the Manchester word transmitter.
package mwt_pkg;
    // Frame format resolved from the select inputs
    typedef enum logic [1:0] {
        MODE_NONE     = 2'd0,
        MODE_SHORT    = 2'd1,
        MODE_WORD     = 2'd2,
        MODE_WORD_PAR = 2'd3
    } frame_mode_e;
endpackage

// File: rtl/mwt_sync_edge.sv
// Synchronizes an asynchronous level and emits a one-cycle pulse on its
// rising edge. Assumes the input is held for at least one clock per level.
module mwt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Capture the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise_pulse = chain[STAGES-1] & ~last_q;

    // R7: an edge produces exactly one start pulse
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/mwt_frame_sel.sv
// Resolves the three frame selects into one format with fixed priority:
// short word first, then 34-bit, then 35-bit; none set means no frame.
module mwt_frame_sel (
    input  logic                sel_short,
    input  logic                sel_34,
    input  logic                sel_35,
    output mwt_pkg::frame_mode_e mode
);
    import mwt_pkg::*;

    // Priority decode of the format selects
    always_comb begin
        if (sel_short)   mode = MODE_SHORT;
        else if (sel_34) mode = MODE_WORD;
        else if (sel_35) mode = MODE_WORD_PAR;
        else             mode = MODE_NONE;
    end
endmodule

// File: rtl/mwt_serializer.sv
// Captures the word registers on the load strobe and shifts the selected
// frame out as Manchester halves. Assumes load_n is synchronous to clk.
// Parity is accumulated serially over sync, identifier and data bits.
module mwt_serializer #(
    parameter int DATA_W    = 32,
    parameter int SHORT_W   = 4,
    parameter int HALF_CLKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_n,
    input  logic [DATA_W-1:0]    word_in,
    input  logic                 sync_in,
    input  logic                 ident_in,
    input  logic [SHORT_W-1:0]   short_in,
    input  logic                 go,
    input  mwt_pkg::frame_mode_e mode,
    input  logic                 odd_par,
    output logic                 active,
    output logic                 enc
);
    import mwt_pkg::*;

    localparam int LONG_W = DATA_W + 2;
    localparam int BIT_W  = $clog2(LONG_W + 2);
    localparam int TICK_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic                load_q;
    logic [DATA_W-1:0]   word_q;
    logic                sync_q;
    logic                ident_q;
    logic [SHORT_W-1:0]  short_q;

    logic [LONG_W-1:0]   long_sh;
    logic [SHORT_W-1:0]  short_sh;
    logic                short_mode_q;
    logic                with_par_q;
    logic                odd_q;
    logic [BIT_W-1:0]    len_q;
    logic [BIT_W-1:0]    bit_idx;
    logic [TICK_W-1:0]   tick;
    logic                half;
    logic                par_acc;
    logic                cur_bit;

    // Track previous load level to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b1;
        else        load_q <= load_n;
    end

    // Capture the input registers on the load rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            sync_q  <= 1'b0;
            ident_q <= 1'b0;
            short_q <= '0;
        end else if (load_n && !load_q) begin
            word_q  <= word_in;
            sync_q  <= sync_in;
            ident_q <= ident_in;
            short_q <= short_in;
        end
    end

    // Select the bit in flight: short word, parity slot, or long shifter
    always_comb begin
        if (short_mode_q)
            cur_bit = short_sh[SHORT_W-1];
        else if (with_par_q && (bit_idx == BIT_W'(LONG_W)))
            cur_bit = par_acc ^ odd_q;
        else
            cur_bit = long_sh[LONG_W-1];
    end

    assign enc = cur_bit ^ half;

    // Frame controller: start, half-bit timing, shifting, parity, stop
    always_ff @(posedge clk) begin
        if (!rst_n || !load_n) begin
            active       <= 1'b0;
            long_sh      <= '0;
            short_sh     <= '0;
            short_mode_q <= 1'b0;
            with_par_q   <= 1'b0;
            odd_q        <= 1'b0;
            len_q        <= '0;
            bit_idx      <= '0;
            tick         <= '0;
            half         <= 1'b0;
            par_acc      <= 1'b0;
        end else if (!active) begin
            if (go && (mode != MODE_NONE)) begin
                active       <= 1'b1;
                long_sh      <= {sync_q, ident_q, word_q};
                short_sh     <= short_q;
                short_mode_q <= (mode == MODE_SHORT);
                with_par_q   <= (mode == MODE_WORD_PAR);
                odd_q        <= odd_par;
                case (mode)
                    MODE_SHORT:    len_q <= BIT_W'(SHORT_W);
                    MODE_WORD:     len_q <= BIT_W'(LONG_W);
                    default:       len_q <= BIT_W'(LONG_W + 1);
                endcase
                bit_idx      <= '0;
                tick         <= '0;
                half         <= 1'b0;
                par_acc      <= 1'b0;
            end
        end else if (tick == TICK_W'(HALF_CLKS - 1)) begin
            tick <= '0;
            if (!half) begin
                half <= 1'b1;
            end else begin
                half     <= 1'b0;
                par_acc  <= par_acc ^ cur_bit;
                long_sh  <= {long_sh[LONG_W-2:0], 1'b0};
                short_sh <= {short_sh[SHORT_W-2:0], 1'b0};
                if (bit_idx == len_q - 1'b1) active <= 1'b0;
                else                          bit_idx <= bit_idx + 1'b1;
            end
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // R8: the bit counter never runs past the selected frame length
    assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_idx < len_q));

    // R2: the parity slot is reached only in the parity-carrying format
    assert_parity_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !short_mode_q && bit_idx == BIT_W'(LONG_W)) |-> with_par_q);

    // R5: a short frame stays within the short word
    assert_short_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && short_mode_q) |-> (bit_idx < BIT_W'(SHORT_W)));

    // R1: the coded level holds for the whole of a half-bit
    assert_half_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && tick != '0) |-> $stable(enc));
endmodule

// File: rtl/mwt_out_steer.sv
// Steers the coded stream to the line or self-test pair and applies the
// rest levels. The inhibit override is purely combinational (asynchronous).
module mwt_out_steer (
    input  logic active,
    input  logic enc,
    input  logic tx_path,
    input  logic inhibit_n,
    output logic line_p,
    output logic line_n,
    output logic test_p,
    output logic test_n
);
    logic drive_line;
    logic drive_test;

    assign drive_line = active & tx_path & inhibit_n;
    assign drive_test = active & ~tx_path & inhibit_n;

    // Line pair: coded stream when selected, otherwise rests high
    always_comb begin
        line_p = drive_line ? enc  : 1'b1;
        line_n = drive_line ? ~enc : 1'b1;
    end

    // Self-test pair: coded stream when selected, otherwise rests low
    always_comb begin
        test_p = drive_test ? enc  : 1'b0;
        test_n = drive_test ? ~enc : 1'b0;
    end
endmodule

// File: rtl/manch_word_tx.sv
// Top of the Manchester word transmitter. Captures a word on the load
// strobe, starts a frame on a synchronized enable edge, and steers the
// coded stream to the line or self-test pair. Assumes load_n is synchronous.
module manch_word_tx #(
    parameter int DATA_W      = 32,
    parameter int SHORT_W     = 4,
    parameter int HALF_CLKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [DATA_W-1:0]  word_in,
    input  logic               sync_in,
    input  logic               ident_in,
    input  logic [SHORT_W-1:0] short_in,
    input  logic               sel_short,
    input  logic               sel_34,
    input  logic               sel_35,
    input  logic               odd_par,
    input  logic               start,
    input  logic               tx_path,
    input  logic               inhibit_n,
    output logic               line_p,
    output logic               line_n,
    output logic               test_p,
    output logic               test_n,
    output logic               tx_idle
);
    import mwt_pkg::*;

    logic        go;
    logic        active;
    logic        enc;
    frame_mode_e mode;

    mwt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (start),
        .rise_pulse (go)
    );

    mwt_frame_sel u_sel (
        .sel_short (sel_short),
        .sel_34    (sel_34),
        .sel_35    (sel_35),
        .mode      (mode)
    );

    mwt_serializer #(
        .DATA_W    (DATA_W),
        .SHORT_W   (SHORT_W),
        .HALF_CLKS (HALF_CLKS)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .word_in  (word_in),
        .sync_in  (sync_in),
        .ident_in (ident_in),
        .short_in (short_in),
        .go       (go),
        .mode     (mode),
        .odd_par  (odd_par),
        .active   (active),
        .enc      (enc)
    );

    mwt_out_steer u_steer (
        .active    (active),
        .enc       (enc),
        .tx_path   (tx_path),
        .inhibit_n (inhibit_n),
        .line_p    (line_p),
        .line_n    (line_n),
        .test_p    (test_p),
        .test_n    (test_n)
    );

    assign tx_idle = ~active;

    // R4: with no format selected an idle block stays idle
    assert_illegal_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !sel_short && !sel_34 && !sel_35 && load_n) |=> tx_idle);

    // R6: holding load low returns the block to idle
    assert_load_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> tx_idle);

    // R11: rest levels on both pairs when no frame is in flight
    assert_rest_levels_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (line_p && line_n && !test_p && !test_n));

    // R9: during a line frame the line pair is complementary, test pair low
    assert_line_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle && tx_path && inhibit_n) |-> ((line_p != line_n) && !test_p && !test_n));

    // R10: inhibit forces rest levels regardless of the frame
    assert_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> (line_p && line_n && !test_p && !test_n));
endmodule

// File: tb/tb_manch_word_tx.sv
module tb_manch_word_tx;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_n;
    logic [31:0] word_in;
    logic        sync_in, ident_in;
    logic [3:0]  short_in;
    logic        sel_short, sel_34, sel_35, odd_par;
    logic        start, tx_path, inhibit_n;
    logic        line_p, line_n, test_p, test_n, tx_idle;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    manch_word_tx dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .word_in(word_in),
        .sync_in(sync_in), .ident_in(ident_in), .short_in(short_in),
        .sel_short(sel_short), .sel_34(sel_34), .sel_35(sel_35),
        .odd_par(odd_par), .start(start), .tx_path(tx_path),
        .inhibit_n(inhibit_n), .line_p(line_p), .line_n(line_n),
        .test_p(test_p), .test_n(test_n), .tx_idle(tx_idle)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Outputs packed as {line_p,line_n,test_p,test_n}
    function automatic logic [3:0] outs();
        return {line_p, line_n, test_p, test_n};
    endfunction

    // Expected long frame: index 0 is sent first
    function automatic logic [39:0] long_bits(input logic [31:0] w, input logic s, input logic id, input logic odd);
        logic [39:0] b = '0;
        b[0] = s;
        b[1] = id;
        for (int k = 0; k < 32; k++) b[2+k] = w[31-k];
        b[34] = s ^ id ^ (^w) ^ odd;
        return b;
    endfunction

    function automatic logic [39:0] short_bits(input logic [3:0] sw);
        logic [39:0] b = '0;
        for (int k = 0; k < 4; k++) b[k] = sw[3-k];
        return b;
    endfunction

    task automatic do_load(input logic [31:0] w, input logic s, input logic id, input logic [3:0] sw);
        word_in = w; sync_in = s; ident_in = id; short_in = sw; load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
        word_in = ~w; sync_in = ~s; ident_in = ~id; short_in = ~sw;  // R6: later changes ignored
        @(negedge clk);
    endtask

    task automatic set_mode(input logic s4, input logic s34, input logic s35, input logic op, input logic path);
        sel_short = s4; sel_34 = s34; sel_35 = s35; odd_par = op; tx_path = path;
    endtask

    // Starts a frame and compares every cycle with the expected waveform
    task automatic run_frame(input int nb, input logic [39:0] eb, input logic path, input string req, input bit retrig);
        int bad = 0;
        logic [3:0] fa = '0, fe = '0;
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(tx_idle === 1'b1, "R7 latency early", {63'd0, tx_idle}, 64'd1);
        @(negedge clk);
        chk(tx_idle === 1'b0, "R7 latency", {63'd0, tx_idle}, 64'd0);
        for (int c = 0; c < nb * 4; c++) begin
            logic e;
            logic [3:0] x;
            e = eb[c/4] ^ ((c % 4) >= 2);
            x = path ? {e, ~e, 2'b00} : {2'b11, e, ~e};
            if (outs() !== x || tx_idle !== 1'b0) begin
                if (bad == 0) begin fa = outs(); fe = x; end
                bad++;
            end
            if (retrig && c == 20) start = 1'b1;
            if (retrig && c == 24) start = 1'b0;
            @(negedge clk);
        end
        chk(bad == 0, req, {60'd0, fa}, {60'd0, fe});
        chk(tx_idle === 1'b1, "R8 frame end", {63'd0, tx_idle}, 64'd1);
        chk(outs() === 4'b1100, "R11 rest after frame", {60'd0, outs()}, 64'hC);
    endtask

    task automatic test_reset();
        chk(tx_idle === 1'b1 && outs() === 4'b1100, "R11 reset state", {59'd0, tx_idle, outs()}, 64'h1C);
    endtask

    task automatic test_word34();
        do_load(32'hA5C3_0F81, 1'b1, 1'b0, 4'h6);
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        run_frame(34, long_bits(32'hA5C3_0F81, 1'b1, 1'b0, 1'b0), 1'b1, "R1 R6 R9 34-bit line", 1'b0);
    endtask

    task automatic test_even_parity();
        do_load(32'h0000_0007, 1'b1, 1'b1, 4'h0);
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        run_frame(35, long_bits(32'h0000_0007, 1'b1, 1'b1, 1'b0), 1'b1, "R2 even parity", 1'b0);
    endtask

    task automatic test_odd_parity_selftest();
        do_load(32'hFFFF_0001, 1'b1, 1'b0, 4'h0);
        set_mode(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        run_frame(35, long_bits(32'hFFFF_0001, 1'b1, 1'b0, 1'b1), 1'b0, "R2 R9 odd parity self-test", 1'b0);
        chk(outs() === 4'b1100, "R11 rest with self-test path", {60'd0, outs()}, 64'hC);
    endtask

    task automatic test_short_priority();
        do_load(32'h1234_5678, 1'b1, 1'b1, 4'b1011);
        set_mode(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        run_frame(4, short_bits(4'b1011), 1'b1, "R3 R5 short frame wins", 1'b0);
        do_load(32'h8000_0000, 1'b1, 1'b0, 4'b0100);
        set_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_frame(4, short_bits(4'b0100), 1'b0, "R5 short frame self-test", 1'b0);
    endtask

    task automatic test_34_over_35();
        do_load(32'h0F0F_F0F0, 1'b1, 1'b1, 4'h0);
        set_mode(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        run_frame(34, long_bits(32'h0F0F_F0F0, 1'b1, 1'b1, 1'b0), 1'b1, "R3 34-bit over 35-bit", 1'b0);
    endtask

    task automatic test_illegal();
        int moved = 0;
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        start = 1'b1;
        for (int c = 0; c < 16; c++) begin
            if (c == 4) start = 1'b0;
            @(negedge clk);
            if (tx_idle !== 1'b1 || outs() !== 4'b1100) moved++;
        end
        chk(moved == 0, "R4 illegal mode sends nothing", moved, 0);
    endtask

    task automatic test_retrigger();
        int moved = 0;
        do_load(32'hDEAD_BEEF, 1'b1, 1'b0, 4'h0);
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        run_frame(34, long_bits(32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0), 1'b1, "R7 mid-frame edge ignored", 1'b1);
        for (int c = 0; c < 12; c++) begin
            if (tx_idle !== 1'b1) moved++;
            @(negedge clk);
        end
        chk(moved == 0, "R7 no second frame", moved, 0);
    endtask

    task automatic test_load_abort();
        do_load(32'h5555_5555, 1'b1, 1'b0, 4'h0);
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        start = 1'b1;
        repeat (12) @(negedge clk);
        start = 1'b0;
        chk(tx_idle === 1'b0, "R6 frame under way", {63'd0, tx_idle}, 64'd0);
        load_n = 1'b0;
        @(negedge clk);
        chk(tx_idle === 1'b1 && outs() === 4'b1100, "R6 load clears frame", {59'd0, tx_idle, outs()}, 64'h1C);
        load_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_inhibit();
        do_load(32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0);
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        start = 1'b1;
        repeat (8) @(negedge clk);
        start = 1'b0;
        #1 inhibit_n = 1'b0;
        #0.5;
        chk(outs() === 4'b1100, "R10 inhibit line path", {60'd0, outs()}, 64'hC);
        tx_path = 1'b0;
        #0.5;
        chk(outs() === 4'b1100, "R10 inhibit self-test path", {60'd0, outs()}, 64'hC);
        @(negedge clk);
        inhibit_n = 1'b1;
        #0.5;
        chk(outs()[1] !== outs()[0] && outs()[3:2] === 2'b11, "R9 self-test pair after inhibit", {60'd0, outs()}, 64'hC);
        tx_path = 1'b1;
        while (tx_idle !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; load_n = 1'b1; word_in = '0; sync_in = 1'b0; ident_in = 1'b0;
        short_in = '0; sel_short = 1'b0; sel_34 = 1'b0; sel_35 = 1'b0; odd_par = 1'b0;
        start = 1'b0; tx_path = 1'b1; inhibit_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_word34();
        test_even_parity();
        test_odd_parity_selftest();
        test_short_priority();
        test_34_over_35();
        test_illegal();
        test_retrigger();
        test_load_abort();
        test_inhibit();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule